// File: doc/BRIEF.md
# Multi-Pad Serial Poller with Delayed Sampling

This block is the host side of a shift-register game pad link. A shared latch line, a shared serial clock line and one data line per pad connect it to up to four pads. A single-cycle start request begins a poll. The block raises the latch line for a fixed number of cycles to freeze every pad's button state. It then runs 24 serial clock periods. During each period the clock line is pulled low and every data line is captured together. The clock line then returns high so the pads shift to their next bit.

The capture does not happen on the falling clock edge. It happens a programmable number of cycles later, at the end of the low period. Some pads emulate a shift register in firmware and change their output late, sometimes close to the falling edge. The delay gives such pads time to settle. A pad built from a true hardware shift register gives the same result, because its data already holds from the previous rising edge. When all 24 bits are in, each pad's captured word is presented in full at the same moment as a single-cycle done pulse.

Top module: `multi_pad_poller`

## Requirements
- R1: While reset is held and after it is released, the outputs are: latch low, serial clock high, done low, and all captured words zero.
- R2: Whenever no poll is running, including the done cycle, latch is low and the serial clock is high.
- R3: Latch rises in the cycle after start_i is sampled high in idle. It stays high for exactly LATCH_CYC cycles, and the serial clock stays high while latch is high.
- R4: Each poll produces exactly 24 serial clock low periods. Each low period lasts SAMPLE_DLY cycles. The low periods are separated by high periods of CLK_HIGH_CYC cycles. The first low period begins in the same cycle that latch returns low.
- R5: Each data input is captured at the clock edge that ends a low period. Only the value present in the last low cycle counts. Values shown earlier in the low period, or while the clock is high, have no effect.
- R6: The bit received k-th in a poll (k = 0 first) is stored at bit 23-k of the pad word. Each group of 8 bits therefore occupies one byte, first bit in its MSB, with the first group in bits 23:16.
- R7: The word of pad p sits at words_o[24p+23:24p] and depends only on data_i[p].
- R8: done_o is high for exactly one cycle. It rises LATCH_CYC + 24*(SAMPLE_DLY+CLK_HIGH_CYC) cycles after latch rises.
- R9: A start_i pulse that arrives while a poll is running is ignored. No extra latch pulse follows, and the poll's timing and done pulse are unchanged.
- R10: words_o holds its value in every cycle except the done cycle. In the done cycle all pad words are replaced together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Poll request, sampled in idle only |
| data_i | input | NUM_PADS | Serial data from each pad |
| latch_o | output | 1 | Shared latch line to the pads |
| pclk_o | output | 1 | Shared serial clock line to the pads, idles high |
| done_o | output | 1 | Single-cycle pulse when the new words are valid |
| words_o | output | NUM_PADS*24 | Captured words, pad p in bits 24p+23:24p |

## Verification
On every cycle, the assertions check the line-level protocol: the latch and low-period widths, that the clock is high while latch is high, that the clock falls as latch drops, idle levels at done, the single-cycle done pulse, and that the words stay frozen outside done. Only the bench's scenarios can show that the sample point really sits at the end of the low period. For that, the bench uses a slow pad model that drives the inverted bit for all but the last low cycle. The scenarios also show bit ordering and pad independence through distinct per-pad patterns, the total poll length, and that a start request in mid-poll leaves no trace.

// File: rtl/multi_pad_poller_pkg.sv
package multi_pad_poller_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LATCH = 2'd1,
    PH_LOW   = 2'd2,
    PH_HIGH  = 2'd3
  } phase_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= value_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/poll_seq.sv
module poll_seq
  import multi_pad_poller_pkg::*;
#(
  parameter int unsigned BITS         = 24,
  parameter int unsigned LATCH_CYC    = 4,
  parameter int unsigned SAMPLE_DLY   = 7,
  parameter int unsigned CLK_HIGH_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic latch_o,
  output logic pclk_o,
  output logic sample_o,
  output logic commit_o,
  output logic done_o
);

  localparam int unsigned MAX_CYC = max3(LATCH_CYC, SAMPLE_DLY, CLK_HIGH_CYC);
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam int unsigned BIT_W   = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CNT_W-1:0] LATCH_LD = CNT_W'(LATCH_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_LD   = CNT_W'(SAMPLE_DLY - 1);
  localparam logic [CNT_W-1:0] HIGH_LD  = CNT_W'(CLK_HIGH_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS - 1);

  phase_e           state_q, state_d;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;
  logic [BIT_W-1:0] bit_q;
  logic             bit_inc;
  logic             latch_q, pclk_q, done_q;

  phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .value_i  (load_val),
    .expired_o(expired)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    sample_o = 1'b0;
    commit_o = 1'b0;
    bit_inc  = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (start_i) begin
          state_d  = PH_LATCH;
          load     = 1'b1;
          load_val = LATCH_LD;
        end
      end
      PH_LATCH: begin
        if (expired) begin
          state_d  = PH_LOW;
          load     = 1'b1;
          load_val = LOW_LD;
        end
      end
      PH_LOW: begin
        // capture point: last cycle of the low period
        if (expired) begin
          sample_o = 1'b1;
          state_d  = PH_HIGH;
          load     = 1'b1;
          load_val = HIGH_LD;
        end
      end
      PH_HIGH: begin
        if (expired) begin
          if (bit_q == LAST_BIT) begin
            commit_o = 1'b1;
            state_d  = PH_IDLE;
          end else begin
            bit_inc  = 1'b1;
            state_d  = PH_LOW;
            load     = 1'b1;
            load_val = LOW_LD;
          end
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      bit_q   <= '0;
      latch_q <= 1'b0;
      pclk_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (commit_o)     bit_q <= '0;
      else if (bit_inc) bit_q <= bit_q + 1'b1;
      // line drivers registered from next phase: glitch-free pins
      latch_q <= (state_d == PH_LATCH);
      pclk_q  <= (state_d != PH_LOW);
      done_q  <= commit_o;
    end
  end

  assign latch_o = latch_q;
  assign pclk_o  = pclk_q;
  assign done_o  = done_q;

endmodule

// File: rtl/pad_lane.sv
module pad_lane #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              commit_i,
  input  logic              data_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      word_q  <= '0;
    end else begin
      if (sample_i) shift_q <= {shift_q[WORD_W-2:0], data_i};
      if (commit_i) word_q  <= shift_q;
    end
  end

  assign word_o = word_q;

endmodule

// File: rtl/multi_pad_poller.sv
module multi_pad_poller #(
  parameter int unsigned NUM_PADS     = 4,
  parameter int unsigned GROUPS       = 3,
  parameter int unsigned GROUP_BITS   = 8,
  parameter int unsigned LATCH_CYC    = 4,
  parameter int unsigned SAMPLE_DLY   = 7,
  parameter int unsigned CLK_HIGH_CYC = 6,
  localparam int unsigned WORD_W      = GROUPS * GROUP_BITS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [NUM_PADS-1:0]        data_i,
  output logic                       latch_o,
  output logic                       pclk_o,
  output logic                       done_o,
  output logic [NUM_PADS*WORD_W-1:0] words_o
);

  logic sample;
  logic commit;

  poll_seq #(
    .BITS        (WORD_W),
    .LATCH_CYC   (LATCH_CYC),
    .SAMPLE_DLY  (SAMPLE_DLY),
    .CLK_HIGH_CYC(CLK_HIGH_CYC)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .latch_o (latch_o),
    .pclk_o  (pclk_o),
    .sample_o(sample),
    .commit_o(commit),
    .done_o  (done_o)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_lane
    pad_lane #(.WORD_W(WORD_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sample_i(sample),
      .commit_i(commit),
      .data_i  (data_i[p]),
      .word_o  (words_o[p*WORD_W +: WORD_W])
    );
  end

endmodule

// File: rtl/multi_pad_poller_chk.sv
module multi_pad_poller_chk #(
  parameter int unsigned LATCH_CYC  = 4,
  parameter int unsigned SAMPLE_DLY = 7,
  parameter int unsigned WORDS_W    = 96
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               latch_i,
  input logic               pclk_i,
  input logic               done_i,
  input logic [WORDS_W-1:0] words_i
);

  logic [15:0] low_run_q;
  logic [15:0] latch_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q   <= '0;
      latch_run_q <= '0;
    end else begin
      low_run_q   <= pclk_i  ? 16'd0 : low_run_q + 16'd1;
      latch_run_q <= latch_i ? latch_run_q + 16'd1 : 16'd0;
    end
  end

  AST_LATCH_CLK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |-> pclk_i); // R3
  AST_LATCH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_i) |-> latch_run_q == 16'(LATCH_CYC)); // R3
  AST_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pclk_i) |-> low_run_q == 16'(SAMPLE_DLY)); // R4
  AST_FIRST_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_i) |-> !pclk_i); // R4
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!latch_i && pclk_i)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R8
  AST_WORDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(words_i)); // R10

endmodule

bind multi_pad_poller multi_pad_poller_chk #(
  .LATCH_CYC (LATCH_CYC),
  .SAMPLE_DLY(SAMPLE_DLY),
  .WORDS_W   (NUM_PADS * WORD_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .latch_i(latch_o),
  .pclk_i (pclk_o),
  .done_i (done_o),
  .words_i(words_o)
);

// File: tb/multi_pad_poller_test.sv
module multi_pad_poller_test;

  localparam int CLK_P = 10;
  localparam int NP    = 4;
  localparam int WW    = 24;
  localparam int LC    = 4;
  localparam int SD    = 7;
  localparam int HC    = 6;
  localparam int POLL  = 1 + LC + WW * (SD + HC);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [NP-1:0]     data;
  logic              latch, pclk, done;
  logic [NP*WW-1:0]  words;

  int vectors = 0;
  int errors  = 0;

  logic [WW-1:0]    pat [NP];
  logic [NP*WW-1:0] words_ref = '0;

  // pad model and line monitor state
  int idx = 0, low_cnt = 0;
  logic pclk_prev = 1'b1, latch_prev = 1'b0;
  int low_run = 0, high_run = 0, latch_run = 0;
  int falls = 0, low_bad = 0, high_bad = 0, latch_bad = 0, latch_rises = 0;
  int gap_bad = 0, words_bad = 0, idle_bad = 0;
  bit seen_low = 0;

  always #(CLK_P/2) clk = ~clk;

  multi_pad_poller uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .start_i(start),
    .data_i (data),
    .latch_o(latch),
    .pclk_o (pclk),
    .done_o (done),
    .words_o(words)
  );

  // slow pad: drives the inverted bit except in the last low cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      idx = 0; low_cnt = 0; pclk_prev = 1'b1; latch_prev = 1'b0;
    end else begin
      if (latch && !latch_prev) begin
        latch_rises++; latch_run = 0; seen_low = 0; falls = 0;
      end
      if (latch) latch_run++;
      if (!latch && latch_prev) begin
        if (latch_run != LC) latch_bad++;
        if (pclk) gap_bad++;
      end
      if (latch && !pclk) latch_bad++;
      if (pclk_prev && !pclk) begin
        falls++;
        if (seen_low && high_run != HC) high_bad++;
        low_run = 0;
      end
      if (!pclk_prev && pclk) begin
        if (low_run != SD) low_bad++;
        seen_low = 1; high_run = 0;
      end
      if (!pclk) low_run++; else high_run++;
      if (done && (latch || !pclk)) idle_bad++;
      if (!done && words !== words_ref) words_bad++;
      if (latch) idx = 0;
      else if (!pclk_prev && pclk) idx++;
      if (!pclk) low_cnt++; else low_cnt = 0;
      pclk_prev = pclk; latch_prev = latch;
    end
    for (int p = 0; p < NP; p++) begin
      logic b;
      b = (idx < WW) ? pat[p][WW-1-idx] : 1'b1;
      data[p] = (!pclk && low_cnt < SD) ? ~b : b;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [NP*WW-1:0] act, input logic [NP*WW-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(latch == 1'b0 && pclk == 1'b1 && done == 1'b0 && words == '0, "R1",
        "levels in reset", {latch, pclk, done}, 3'b010);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(latch == 1'b0 && pclk == 1'b1 && done == 1'b0 && words == '0, "R1",
        "levels after reset", {latch, pclk, done}, 3'b010);
    chk(latch == 1'b0 && pclk == 1'b1, "R2", "idle lines", {latch, pclk}, 2'b01);
  endtask

  // one full poll; a second start is pulsed at count mid_at when nonzero
  task automatic t_poll(input string name, input int mid_at);
    int n;
    logic [NP*WW-1:0] exp;
    low_bad = 0; high_bad = 0; latch_bad = 0; latch_rises = 0; gap_bad = 0;
    words_bad = 0; idle_bad = 0;
    for (int p = 0; p < NP; p++) exp[p*WW +: WW] = pat[p];
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 4 * POLL) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = (mid_at != 0 && n == mid_at);
    end
    start = 1'b0;
    $display("-- %s", name);
    chk(n == POLL, "R8", "done latency", n, POLL);
    chk(words == exp, "R6", "word bit order", words, exp);
    for (int p = 0; p < NP; p++)
      chk(words[p*WW +: WW] == pat[p], "R7", "pad word slot", words[p*WW +: WW], pat[p]);
    chk(falls == WW, "R4", "clock low periods", falls, WW);
    chk(low_bad == 0 && high_bad == 0 && gap_bad == 0, "R4", "clock phase widths",
        low_bad + high_bad + gap_bad, 0);
    chk(latch_bad == 0 && latch_rises == 1, "R3", "latch pulse", latch_rises, 1);
    chk(idle_bad == 0, "R2", "lines at done", idle_bad, 0);
    words_ref = exp;
    @(negedge clk);
    chk(done == 1'b0, "R8", "done single cycle", done, 0);
    repeat (12) @(negedge clk);
    chk(latch_rises == 1 && latch == 1'b0 && pclk == 1'b1, "R9",
        "no extra poll after done", latch_rises, 1);
    chk(words_bad == 0, "R10", "words frozen outside done", words_bad, 0);
    chk(words == exp, "R5", "late sample survives early glitch", words, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    data = '1;
    for (int p = 0; p < NP; p++) pat[p] = '1;
    t_reset();
    for (int p = 0; p < NP; p++) pat[p] = '0;
    t_poll("all pressed", 0);
    for (int p = 0; p < NP; p++) pat[p] = '1;
    t_poll("all released", 0);
    pat[0] = 24'hA53C0F; pat[1] = 24'h8001FE; pat[2] = 24'h7E1281; pat[3] = 24'hC39669;
    t_poll("distinct pads", 0);
    for (int p = 0; p < NP; p++) pat[p] = 24'h000001 << (p * 5 + 2);
    t_poll("start during poll, R9", 40);
    pat[0] = 24'h123456; pat[1] = 24'hFEDCBA; pat[2] = 24'h0F0F0F; pat[3] = 24'h5A5A5A;
    t_poll("start late in poll, R9", POLL - 3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule